// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block divides its own clock by a ratio that changes from one division to the next. The long-run average of that ratio equals INT + FRAC/MOD. A third-order cascade of three accumulators produces a small signed offset for each division. Each accumulator wraps at an arbitrary modulus MOD, not at a power of two. The offset is added to the integer part, and the result reloads a down-counter. The counter emits one single-cycle pulse each time a division completes. In a fractional-N loop the clock input is the prescaled oscillator signal and the pulse goes to the phase detector.

The register inputs are captured only on the load strobe, and only after being clamped into their legal ranges. The captured values wait until the current division ends. At that boundary they become active and all accumulators and delay stages restart from zero. A zero numerator therefore gives a clean integer-N ratio with no dither.

Top module: `fracn_fbdiv`

## Requirements
- R1: While reset is low, `pulse_o` stays low. After reset, with no load issued, every division lasts 31 clocks.
- R2: With FRAC = 0, every division lasts exactly INT clocks.
- R3: Over MOD×k consecutive divisions that start at the boundary where a configuration takes effect, the total number of clocks lies within −1 to +2 of (INT×MOD + FRAC)×k.
- R4: Every single division lasts between INT−3 and INT+4 clocks.
- R5: With FRAC = MOD, every division lasts exactly INT+1 clocks.
- R6: A load changes nothing in the division in progress. The new ratio applies from the next division onward.
- R7: Changes on `int_val_i`, `frac_num_i` or `mod_den_i` without a load strobe do not affect the divisions.
- R8: An INT below 31 is treated as 31.
- R9: A MOD below 2 is treated as 2.
- R10: A FRAC above the (clamped) MOD is treated as equal to MOD.
- R11: `pulse_o` is high for exactly one clock per division.
- R12: With 0 < FRAC < MOD, the division lengths are not all equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| int_val_i | input | 8 | Integer part of the ratio (legal 31..255) |
| frac_num_i | input | 12 | Fractional numerator (legal 0..MOD) |
| mod_den_i | input | 12 | Fractional modulus (legal 2..4095) |
| load_i | input | 1 | Strobe that captures the three register inputs |
| pulse_o | output | 1 | One-clock pulse per completed division |

## Verification
A loaded configuration does not act on the division in progress. It governs the division that starts at the next terminal count, and `pulse_o` rises one clock after that terminal count. So the distance between two pulses is the length of one division. After each strobe the bench waits for the first pulse that follows it and starts measuring only from that pulse. The scoreboard then compares each later pulse interval with a queued expected length, or sums the intervals over whole MOD-length windows. For the hand-off case, the strobe is placed inside a division whose length is already known. The two queued intervals are the old ratio followed by the new one.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  parameter int INT_W   = 8;
  parameter int MOD_W   = 12;
  parameter int INT_MIN = 31;
  parameter int MOD_MIN = 2;
  parameter int OFFS_W  = 4;
  parameter int STAGES  = 3;
  typedef logic signed [OFFS_W-1:0] offs_t;
endpackage

// File: rtl/fnd_acc.sv
module fnd_acc #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clr_i,
  input  logic [W-1:0] mod_i,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] next_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W:0]   diff;

  // next-state: add, then fold back once into [0, MOD-1]
  always_comb begin
    base    = clr_i ? '0 : acc_q;
    sum     = {1'b0, base} + {1'b0, addend_i};
    diff    = sum - {1'b0, mod_i};
    carry_o = (sum >= {1'b0, mod_i});
    next_o  = carry_o ? diff[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= next_o;
  end
endmodule

// File: rtl/fnd_mash.sv
module fnd_mash
  import fnd_pkg::*;
#(
  parameter int W = MOD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clr_i,
  input  logic [W-1:0] frac_i,
  input  logic [W-1:0] mod_i,
  output offs_t        offs_o
);
  logic [W-1:0] addend [STAGES];
  logic [W-1:0] resid  [STAGES];
  logic         carry  [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign addend[g] = frac_i;
      end else begin : g_tail
        assign addend[g] = resid[g-1];
      end
      fnd_acc #(.W(W)) acc_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (step_i),
        .clr_i    (clr_i),
        .mod_i    (mod_i),
        .addend_i (addend[g]),
        .next_o   (resid[g]),
        .carry_o  (carry[g])
      );
    end
  endgenerate

  // differentiator history for stages 2 and 3
  logic c2_q, c3_q, c3_qq;
  logic c2_d, c3_d, c3_dd;
  logic [OFFS_W-1:0] t1, t2, t3;

  always_comb begin
    c2_d  = clr_i ? 1'b0 : c2_q;
    c3_d  = clr_i ? 1'b0 : c3_q;
    c3_dd = clr_i ? 1'b0 : c3_qq;
    t1 = {{(OFFS_W-1){1'b0}}, carry[0]};
    t2 = {{(OFFS_W-1){1'b0}}, carry[1]} - {{(OFFS_W-1){1'b0}}, c2_d};
    t3 = {{(OFFS_W-1){1'b0}}, carry[2]} - {{(OFFS_W-2){1'b0}}, c3_d, 1'b0}
       + {{(OFFS_W-1){1'b0}}, c3_dd};
    offs_o = offs_t'(t1 + t2 + t3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_q  <= 1'b0;
      c3_q  <= 1'b0;
      c3_qq <= 1'b0;
    end else if (step_i) begin
      c2_q  <= carry[1];
      c3_q  <= carry[2];
      c3_qq <= c3_d;
    end
  end
endmodule

// File: rtl/fnd_cnt.sv
module fnd_cnt #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tc_o  = (cnt_q == '0);
    cnt_d = tc_o ? (ratio_i - W'(1)) : (cnt_q - W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fracn_fbdiv.sv
module fracn_fbdiv
  import fnd_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int MW = MOD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] int_val_i,
  input  logic [MW-1:0] frac_num_i,
  input  logic [MW-1:0] mod_den_i,
  input  logic          load_i,
  output logic          pulse_o
);
  localparam int RW = IW + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  // range clamp of the register inputs
  logic [IW-1:0] cl_int;
  logic [MW-1:0] cl_mod, cl_frac;
  always_comb begin
    cl_int  = (int_val_i < IW'(INT_MIN)) ? IW'(INT_MIN) : int_val_i;
    cl_mod  = (mod_den_i < MW'(MOD_MIN)) ? MW'(MOD_MIN) : mod_den_i;
    cl_frac = (frac_num_i > cl_mod) ? cl_mod : frac_num_i;
  end

  // staged and active configuration
  logic          pend_q, pend_d;
  logic [IW-1:0] pint_q, pint_d, aint_q, aint_d;
  logic [MW-1:0] pfrac_q, pfrac_d, afrac_q, afrac_d;
  logic [MW-1:0] pmod_q, pmod_d, amod_q, amod_d;
  logic          tc, apply;
  logic [IW-1:0] eff_int;
  logic [MW-1:0] eff_frac, eff_mod;
  offs_t         offs;
  logic [RW-1:0] ratio;
  logic          pulse_q;

  always_comb begin
    apply    = tc & pend_q;
    eff_int  = apply ? pint_q  : aint_q;
    eff_frac = apply ? pfrac_q : afrac_q;
    eff_mod  = apply ? pmod_q  : amod_q;

    pend_d  = pend_q;
    pint_d  = pint_q;
    pfrac_d = pfrac_q;
    pmod_d  = pmod_q;
    if (apply) pend_d = 1'b0;
    if (load_i) begin
      pend_d  = 1'b1;
      pint_d  = cl_int;
      pfrac_d = cl_frac;
      pmod_d  = cl_mod;
    end

    aint_d  = eff_int;
    afrac_d = eff_frac;
    amod_d  = eff_mod;

    ratio = {1'b0, eff_int} + {{(RW-OFFS_W){offs[OFFS_W-1]}}, offs};
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      pend_q  <= 1'b0;
      pint_q  <= IW'(INT_MIN);
      pfrac_q <= '0;
      pmod_q  <= MW'(MOD_MIN);
      aint_q  <= IW'(INT_MIN);
      afrac_q <= '0;
      amod_q  <= MW'(MOD_MIN);
      pulse_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pint_q  <= pint_d;
      pfrac_q <= pfrac_d;
      pmod_q  <= pmod_d;
      pulse_q <= tc;
      if (tc) begin
        aint_q  <= aint_d;
        afrac_q <= afrac_d;
        amod_q  <= amod_d;
      end
    end
  end

  fnd_mash #(.W(MW)) mash_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .step_i (tc),
    .clr_i  (apply),
    .frac_i (eff_frac),
    .mod_i  (eff_mod),
    .offs_o (offs)
  );

  fnd_cnt #(.W(RW)) cnt_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .ratio_i (ratio),
    .tc_o    (tc)
  );

  assign pulse_o = pulse_q;
endmodule

// File: rtl/fracn_fbdiv_chk.sv
module fracn_fbdiv_chk
  import fnd_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int MW = MOD_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pulse_o,
  input logic          tc,
  input offs_t         offs,
  input logic [IW-1:0] aint_q,
  input logic [MW-1:0] afrac_q,
  input logic [MW-1:0] amod_q,
  input logic [MW-1:0] eff_frac,
  input logic [MW-1:0] eff_mod
);
  a_r4_offset_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc |-> (offs >= -3 && offs <= 4));
  a_r11_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  a_r8_int_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aint_q >= IW'(INT_MIN));
  a_r9_mod_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amod_q >= MW'(MOD_MIN));
  a_r10_frac_le_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    afrac_q <= amod_q);
  a_r6_hold_midcycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc |=> ($stable(aint_q) && $stable(afrac_q) && $stable(amod_q)));
  a_r2_no_dither: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && eff_frac == '0) |-> offs == 0);
  a_r5_full_frac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && eff_frac == eff_mod) |-> offs == 1);
endmodule

bind fracn_fbdiv fracn_fbdiv_chk #(.IW(IW), .MW(MW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_n_sync),
  .pulse_o  (pulse_o),
  .tc       (tc),
  .offs     (offs),
  .aint_q   (aint_q),
  .afrac_q  (afrac_q),
  .amod_q   (amod_q),
  .eff_frac (eff_frac),
  .eff_mod  (eff_mod)
);

// File: tb/fracn_fbdiv_tb_top.sv
module fracn_fbdiv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  int_r;
  logic [11:0] frac_r, mod_r;
  logic        load;
  logic        pulse;

  always #(2.5ns) clk = ~clk;

  fracn_fbdiv dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .int_val_i  (int_r),
    .frac_num_i (frac_r),
    .mod_den_i  (mod_r),
    .load_i     (load),
    .pulse_o    (pulse)
  );

  typedef struct { int val; string tag; } exp_t;
  exp_t exp_q[$];
  int   col_q[$];
  bit   arm = 0;
  int   errors = 0;
  int   checks = 0;
  int   wide = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: measures pulse-to-pulse intervals at the falling edge
  int  cyc = 0, last = 0;
  bit  seen = 0, prev = 0;
  always @(negedge clk) begin
    cyc++;
    if (pulse && prev) wide++;
    prev = pulse;
    if (pulse) begin
      if (seen && arm) begin
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc - last == e.val, e.tag, cyc - last, e.val);
        end else begin
          col_q.push_back(cyc - last);
        end
      end
      seen = 1;
      last = cyc;
    end
  end

  task automatic load_cfg(input int i, input int f, input int m);
    @(negedge clk);
    int_r = 8'(i); frac_r = 12'(f); mod_r = 12'(m); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic sync_pulse();
    do @(negedge clk); while (!pulse);
    @(posedge clk);
  endtask

  task automatic expect_n(input int n, input int v, input string tag);
    for (int j = 0; j < n; j++) exp_q.push_back('{val: v, tag: tag});
    arm = 1;
    wait (exp_q.size() == 0);
    arm = 0;
  endtask

  task automatic frac_test(input int i, input int f, input int m, input int k,
                           input int ei, input int ef, input int em, input string tag);
    int total, mn, mx, expv;
    load_cfg(i, f, m);
    sync_pulse();
    col_q.delete();
    arm = 1;
    wait (col_q.size() >= em * k);
    arm = 0;
    total = 0; mn = 1000; mx = 0;
    for (int j = 0; j < em * k; j++) begin
      total += col_q[j];
      if (col_q[j] < mn) mn = col_q[j];
      if (col_q[j] > mx) mx = col_q[j];
    end
    expv = (ei * em + ef) * k;
    chk(total >= expv - 1 && total <= expv + 2, {tag, " average"}, total, expv);
    chk(mn >= ei - 3, "R4 min ratio", mn, ei - 3);
    chk(mx <= ei + 4, "R4 max ratio", mx, ei + 4);
    if (ef != 0 && ef != em) chk(mn != mx, "R12 dither present", mx, mn + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load = 1'b0; int_r = '0; frac_r = '0; mod_r = '0;
    repeat (4) @(negedge clk);
    chk(pulse == 1'b0, "R1 pulse low in reset", int'(pulse), 0);
    rst_n = 1'b1;
    sync_pulse();
    expect_n(3, 31, "R1 default ratio");

    load_cfg(100, 0, 5);  sync_pulse(); expect_n(4, 100, "R2 integer 100");
    load_cfg(255, 0, 9);  sync_pulse(); expect_n(3, 255, "R2 integer 255");
    load_cfg(5, 0, 10);   sync_pulse(); expect_n(3, 31,  "R8 int clamp");
    load_cfg(50, 7, 7);   sync_pulse(); expect_n(5, 51,  "R5 frac equals mod");
    load_cfg(60, 20, 9);  sync_pulse(); expect_n(5, 61,  "R10 frac clamp");

    // R6: strobe mid-division; old length finishes, then the new one
    load_cfg(40, 0, 3);
    sync_pulse();
    exp_q.push_back('{val: 40, tag: "R6 in-flight division"});
    exp_q.push_back('{val: 60, tag: "R6 new ratio"});
    exp_q.push_back('{val: 60, tag: "R6 new ratio"});
    arm = 1;
    repeat (5) @(negedge clk);
    int_r = 8'd60; frac_r = '0; mod_r = 12'd3; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    wait (exp_q.size() == 0);
    arm = 0;

    // R7: inputs move without a strobe
    @(negedge clk);
    int_r = 8'd99; frac_r = 12'd1; mod_r = 12'd2;
    sync_pulse();
    expect_n(3, 60, "R7 no strobe no change");

    frac_test(50, 1, 4, 100, 50, 1, 4, "R3 mod4");
    frac_test(100, 3, 7, 20, 100, 3, 7, "R3 mod7");
    frac_test(31, 5, 13, 10, 31, 5, 13, "R3 mod13");
    frac_test(40, 1, 0, 50, 40, 1, 2, "R9 mod clamp");

    chk(wide == 0, "R11 single-cycle pulse", wide, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule